// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block turns a virtual address into a physical address using one global table with a slot for each physical frame. Each slot records which process owns the frame, which virtual page lives there, and a link to the next slot. The walk does not scan the table or index it directly. The request's process ID and virtual page number are folded into an index into a separate anchor table. The anchor gives the first slot to visit. The walker then follows the links from slot to slot until the stored owner and page match the request or the chain runs out. On a hit, the index of the matching slot is the frame number, and it is placed above the page offset to form the physical address.

Both tables are internal register arrays that the surrounding logic loads through two write ports. A request is accepted only while `busy` is low. The walk then takes one clock to read the anchor and one clock for every slot visited. The result comes back with a one-cycle `done` pulse and carries a fault flag and the number of slots visited. A visit limit equal to the table size ends walks on chains that loop back on themselves.

The controller has four states:
- `ST_IDLE` waits for a request and moves to `ST_ANCHOR` when `req_valid` is high.
- `ST_ANCHOR` reads the anchor slot. It moves to `ST_PROBE` when the pointer is valid and to `ST_RESP` when it is not.
- `ST_PROBE` compares one slot per clock. It stays in `ST_PROBE` while it follows a link and moves to `ST_RESP` on a match, on an invalid link, or when the visit limit is reached.
- `ST_RESP` presents the result and always returns to `ST_IDLE`.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `visits` and `paddr` are all zero. Every anchor slot and every slot link holds the null pointer (all ones), so any request made before a table write ends in a fault with 0 visits.
- R2: The anchor index is the XOR fold of the key {process ID, virtual page number}, where the page number occupies the low bits. The key is zero-padded at the top and cut into ANCHOR_W-bit slices starting from bit 0. The walk starts at the slot named by that anchor entry.
- R3: A pointer value of FRAMES or above is invalid. All ones is one such value. If the anchor entry holds an invalid pointer, the walk ends with `fault`=1 and `visits`=0, and `done` pulses right after the first rising edge that follows the accepting edge.
- R4: On a hit, `fault`=0 and `paddr` = {matching slot index, request page offset}.
- R5: On a mismatch, the walker follows the slot's link. A hit at the k-th visited slot reports `visits`=k, and `done` pulses right after the (k+1)-th rising edge that follows the accepting edge.
- R6: If a mismatching slot holds an invalid link, the walk ends with `fault`=1, `paddr`=0, and `visits` equal to the number of slots compared.
- R7: A slot matches only when both its process ID and its virtual page number equal the request's. A slot with the same page number but a different owner is treated as a mismatch.
- R8: A walk that reaches FRAMES visits without a match ends with `fault`=1 and `visits`=FRAMES. `visits` never exceeds FRAMES.
- R9: `req_valid` is ignored while `busy` is high, including the `done` cycle. Such requests do not change the result of the walk in progress, and the controller returns to idle for at least one cycle after `done`.
- R10: A table write affects walks accepted after it. `paddr`, `fault` and `visits` change only in the cycle where `done` is high, and they hold their values until the next `done`.
- R11: `done` is a one-cycle pulse. `busy` rises on the edge that accepts a request and stays high through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken when `busy` is low) |
| req_pid | input | PID_W | Requesting process ID |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Page offset |
| busy | output | 1 | Walk in progress or result being presented |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Last walk ended without a match |
| paddr | output | FRAME_W+OFF_W | Last physical address (zero on fault) |
| visits | output | FRAME_W+1 | Slots compared by the last walk |
| anc_we | input | 1 | Anchor table write enable |
| anc_addr | input | ANCHOR_W | Anchor slot to write |
| anc_ptr | input | FRAME_W+1 | Pointer written to the anchor slot |
| pte_we | input | 1 | Frame table write enable |
| pte_addr | input | FRAME_W | Frame slot to write |
| pte_pid | input | PID_W | Owner process ID written to the slot |
| pte_vpn | input | VPN_W | Virtual page written to the slot |
| pte_next | input | FRAME_W+1 | Link written to the slot |

## Verification
The walker is exercised with several kinds of lookup, and each separates a different failure:
- **Unused anchor.** Lookups that land on an unused anchor, either holding all ones or holding an out-of-range pointer, show that the null test fires before any slot is read.
- **Single-slot chain.** A hit on a one-slot chain checks the frame-to-address join.
- **Three-slot chain.** A three-slot chain with the hit at its tail checks link following and the count of one cycle per visit.
- **Colliding absent key.** Keys built to fold onto the same anchor but absent from the chain separate a full-chain fault from a stopped walk.
- **Owner mismatch.** A key with the same page but another owner shows that the owner takes part in the compare.
- **Looping chain.** Turning the chain into a loop checks the visit limit.
- **Requests held high.** Holding `req_valid` high throughout a walk shows that requests during a walk and during the result cycle are dropped.
- **Slot rewrite.** Rewriting a slot after a hit shows that the new contents govern the next walk.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    // Walk controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ANCHOR = 2'd1,
        ST_PROBE  = 2'd2,
        ST_RESP   = 2'd3
    } walk_state_t;

endpackage

// File: rtl/hpt_fold.sv
// XOR fold of a wide key down to OUT_W bits, lowest slice first.
module hpt_fold #(
    parameter int IN_W  = 28,
    parameter int OUT_W = 6
) (
    input  logic [IN_W-1:0]  key,
    output logic [OUT_W-1:0] folded
);
    localparam int SLICES = (IN_W + OUT_W - 1) / OUT_W;
    localparam int PAD_W  = SLICES * OUT_W;

    logic [PAD_W-1:0] padded;
    logic [OUT_W-1:0] part [SLICES];

    always_comb begin
        padded = '0;
        padded[IN_W-1:0] = key;
    end

    genvar s;
    generate
        for (s = 0; s < SLICES; s++) begin : g_slice
            if (s == 0) begin : g_first
                assign part[s] = padded[OUT_W-1:0];
            end else begin : g_rest
                assign part[s] = part[s-1] ^ padded[s*OUT_W +: OUT_W];
            end
        end
    endgenerate

    assign folded = part[SLICES-1];
endmodule

// File: rtl/hpt_anchor_table.sv
// Anchor table: one pointer per hash bucket, reset to the null pointer.
module hpt_anchor_table #(
    parameter int ANCHOR_W = 6,
    parameter int PTR_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ANCHOR_W-1:0] wr_addr,
    input  logic [PTR_W-1:0]    wr_ptr,
    input  logic [ANCHOR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]    rd_ptr
);
    localparam int DEPTH = 1 << ANCHOR_W;

    logic [PTR_W-1:0] slot [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot[i] <= '1;
            end
        end else if (wr_en) begin
            slot[wr_addr] <= wr_ptr;
        end
    end

    assign rd_ptr = slot[rd_addr];
endmodule

// File: rtl/hpt_entry_table.sv
// Frame table: owner, page and chain link per physical frame.
module hpt_entry_table #(
    parameter int FRAME_W = 5,
    parameter int PID_W   = 8,
    parameter int VPN_W   = 20,
    parameter int PTR_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_addr,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PTR_W-1:0]   wr_next,
    input  logic [FRAME_W-1:0] rd_addr,
    output logic [PID_W-1:0]   rd_pid,
    output logic [VPN_W-1:0]   rd_vpn,
    output logic [PTR_W-1:0]   rd_next
);
    localparam int DEPTH = 1 << FRAME_W;

    logic [PID_W-1:0] own_mem  [DEPTH];
    logic [VPN_W-1:0] page_mem [DEPTH];
    logic [PTR_W-1:0] link_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                own_mem[i]  <= '0;
                page_mem[i] <= '0;
                link_mem[i] <= '1;
            end
        end else if (wr_en) begin
            own_mem[wr_addr]  <= wr_pid;
            page_mem[wr_addr] <= wr_vpn;
            link_mem[wr_addr] <= wr_next;
        end
    end

    assign rd_pid  = own_mem[rd_addr];
    assign rd_vpn  = page_mem[rd_addr];
    assign rd_next = link_mem[rd_addr];
endmodule

// File: rtl/hpt_walker.sv
// Hashed inverted page table walker (top).
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int PID_W    = 8,
    parameter int VPN_W    = 20,
    parameter int OFF_W    = 12,
    parameter int FRAME_W  = 5,
    parameter int ANCHOR_W = 6   // must be >= FRAME_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [PID_W-1:0]           req_pid,
    input  logic [VPN_W-1:0]           req_vpn,
    input  logic [OFF_W-1:0]           req_off,
    output logic                       busy,
    output logic                       done,
    output logic                       fault,
    output logic [FRAME_W+OFF_W-1:0]   paddr,
    output logic [FRAME_W:0]           visits,
    input  logic                       anc_we,
    input  logic [ANCHOR_W-1:0]        anc_addr,
    input  logic [FRAME_W:0]           anc_ptr,
    input  logic                       pte_we,
    input  logic [FRAME_W-1:0]         pte_addr,
    input  logic [PID_W-1:0]           pte_pid,
    input  logic [VPN_W-1:0]           pte_vpn,
    input  logic [FRAME_W:0]           pte_next
);
    localparam int FRAMES = 1 << FRAME_W;
    localparam int PTR_W  = FRAME_W + 1;
    localparam int VIS_W  = FRAME_W + 1;
    localparam int KEY_W  = PID_W + VPN_W;
    localparam logic [PTR_W-1:0] PTR_LIMIT = PTR_W'(FRAMES);
    localparam logic [VIS_W-1:0] VIS_LIMIT = VIS_W'(FRAMES);

    walk_state_t state, state_nx;

    // Latched request
    logic [PID_W-1:0]   lat_pid;
    logic [VPN_W-1:0]   lat_vpn;
    logic [OFF_W-1:0]   lat_off;
    logic [PTR_W-1:0]   cur_ptr;
    logic [VIS_W-1:0]   vis_cnt;

    // Result registers
    logic               res_fault;
    logic [FRAME_W-1:0] res_frame;
    logic [OFF_W-1:0]   res_off;
    logic [VIS_W-1:0]   res_vis;

    // Table read paths
    logic [ANCHOR_W-1:0] bucket;
    logic [PTR_W-1:0]    anc_rd;
    logic [PID_W-1:0]    ent_pid;
    logic [VPN_W-1:0]    ent_vpn;
    logic [PTR_W-1:0]    ent_next;

    // Decisions
    logic               anc_ok;
    logic               link_ok;
    logic               hit;
    logic [VIS_W-1:0]   vis_inc;
    logic               limit_reached;

    hpt_fold #(
        .IN_W  (KEY_W),
        .OUT_W (ANCHOR_W)
    ) u_fold (
        .key    ({lat_pid, lat_vpn}),
        .folded (bucket)
    );

    hpt_anchor_table #(
        .ANCHOR_W (ANCHOR_W),
        .PTR_W    (PTR_W)
    ) u_anchor (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (anc_we),
        .wr_addr (anc_addr),
        .wr_ptr  (anc_ptr),
        .rd_addr (bucket),
        .rd_ptr  (anc_rd)
    );

    hpt_entry_table #(
        .FRAME_W (FRAME_W),
        .PID_W   (PID_W),
        .VPN_W   (VPN_W),
        .PTR_W   (PTR_W)
    ) u_entries (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pte_we),
        .wr_addr (pte_addr),
        .wr_pid  (pte_pid),
        .wr_vpn  (pte_vpn),
        .wr_next (pte_next),
        .rd_addr (cur_ptr[FRAME_W-1:0]),
        .rd_pid  (ent_pid),
        .rd_vpn  (ent_vpn),
        .rd_next (ent_next)
    );

    assign anc_ok        = (anc_rd < PTR_LIMIT);
    assign link_ok       = (ent_next < PTR_LIMIT);
    assign hit           = (ent_pid == lat_pid) && (ent_vpn == lat_vpn);
    assign vis_inc       = vis_cnt + VIS_W'(1);
    assign limit_reached = (vis_inc >= VIS_LIMIT);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_ANCHOR;
            ST_ANCHOR: state_nx = anc_ok ? ST_PROBE : ST_RESP;
            ST_PROBE: begin
                if (hit || !link_ok || limit_reached) state_nx = ST_RESP;
            end
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Walk datapath and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_pid   <= '0;
            lat_vpn   <= '0;
            lat_off   <= '0;
            cur_ptr   <= '1;
            vis_cnt   <= '0;
            res_fault <= 1'b0;
            res_frame <= '0;
            res_off   <= '0;
            res_vis   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_pid <= req_pid;
                        lat_vpn <= req_vpn;
                        lat_off <= req_off;
                        vis_cnt <= '0;
                    end
                end
                ST_ANCHOR: begin
                    cur_ptr <= anc_rd;
                    if (!anc_ok) begin
                        res_fault <= 1'b1;
                        res_frame <= '0;
                        res_off   <= '0;
                        res_vis   <= '0;
                    end
                end
                ST_PROBE: begin
                    vis_cnt <= vis_inc;
                    cur_ptr <= ent_next;
                    if (hit) begin
                        res_fault <= 1'b0;
                        res_frame <= cur_ptr[FRAME_W-1:0];
                        res_off   <= lat_off;
                        res_vis   <= vis_inc;
                    end else if (!link_ok || limit_reached) begin
                        res_fault <= 1'b1;
                        res_frame <= '0;
                        res_off   <= '0;
                        res_vis   <= vis_inc;
                    end
                end
                ST_RESP: begin
                    vis_cnt <= '0;
                end
                default: begin
                    vis_cnt <= '0;
                end
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy = 1'b1;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_ANCHOR: busy = 1'b1;
            ST_PROBE:  busy = 1'b1;
            ST_RESP:   done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign fault  = res_fault;
    assign paddr  = {res_frame, res_off};
    assign visits = res_vis;
endmodule

// File: rtl/hpt_walker_checker.sv
// Temporal checks on the walker's ports, bound to every instance.
module hpt_walker_checker #(
    parameter int FRAME_W = 5,
    parameter int OFF_W   = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     busy,
    input logic                     done,
    input logic                     fault,
    input logic [FRAME_W+OFF_W-1:0] paddr,
    input logic [FRAME_W:0]         visits
);
    localparam int FRAMES = 1 << FRAME_W;

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_raises_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_done_only_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_visit_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        visits <= (FRAME_W+1)'(FRAMES));

    assert_zero_visit_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && visits == '0) |-> fault);

    assert_fault_clears_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (paddr == '0));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(paddr) && $stable(fault) && $stable(visits)));
endmodule

bind hpt_walker hpt_walker_checker #(
    .FRAME_W (FRAME_W),
    .OFF_W   (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .paddr     (paddr),
    .visits    (visits)
);

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
    localparam int PID_W    = 8;
    localparam int VPN_W    = 20;
    localparam int OFF_W    = 12;
    localparam int FRAME_W  = 5;
    localparam int ANCHOR_W = 6;
    localparam int FRAMES   = 1 << FRAME_W;
    localparam int ANCHORS  = 1 << ANCHOR_W;
    localparam int NULLP    = (1 << (FRAME_W + 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [PID_W-1:0] req_pid = '0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic busy, done, fault;
    logic [FRAME_W+OFF_W-1:0] paddr;
    logic [FRAME_W:0] visits;
    logic anc_we = 1'b0;
    logic [ANCHOR_W-1:0] anc_addr = '0;
    logic [FRAME_W:0] anc_ptr = '0;
    logic pte_we = 1'b0;
    logic [FRAME_W-1:0] pte_addr = '0;
    logic [PID_W-1:0] pte_pid = '0;
    logic [VPN_W-1:0] pte_vpn = '0;
    logic [FRAME_W:0] pte_next = '0;

    always #2.5 clk = ~clk;

    hpt_walker #(
        .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
        .FRAME_W(FRAME_W), .ANCHOR_W(ANCHOR_W)
    ) u_hpt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_pid(req_pid), .req_vpn(req_vpn), .req_off(req_off),
        .busy(busy), .done(done), .fault(fault), .paddr(paddr), .visits(visits),
        .anc_we(anc_we), .anc_addr(anc_addr), .anc_ptr(anc_ptr),
        .pte_we(pte_we), .pte_addr(pte_addr), .pte_pid(pte_pid),
        .pte_vpn(pte_vpn), .pte_next(pte_next)
    );

    int vectors = 0;
    int miscompares = 0;
    string tag = "R1";

    // Behavioural reference: 0 idle, 1 walking, 2 result cycle
    int m_phase = 0;
    int m_left = 0;
    int m_fault = 0, m_vis = 0, m_paddr = 0;
    int p_fault = 0, p_vis = 0, p_paddr = 0;
    int m_anc [ANCHORS];
    int m_pid [FRAMES];
    int m_vpn [FRAMES];
    int m_next [FRAMES];

    function automatic int fold_key(int pid, int vpn);
        int h = 0;
        for (int i = 0; i < VPN_W; i++)
            if ((vpn >> i) & 1) h = h ^ (1 << (i % ANCHOR_W));
        for (int i = 0; i < PID_W; i++)
            if ((pid >> i) & 1) h = h ^ (1 << ((VPN_W + i) % ANCHOR_W));
        return h;
    endfunction

    task automatic ref_walk(input int pid, input int vpn, input int off,
                            output int f, output int v, output int pa);
        int p;
        p = m_anc[fold_key(pid, vpn)];
        f = 0; v = 0; pa = 0;
        forever begin
            if (p >= FRAMES) begin f = 1; return; end
            v++;
            if (m_pid[p] == pid && m_vpn[p] == vpn) begin
                pa = (p << OFF_W) | off;
                return;
            end
            if (v >= FRAMES) begin f = 1; return; end
            p = m_next[p];
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0;
            m_fault = 0; m_vis = 0; m_paddr = 0;
            for (int i = 0; i < ANCHORS; i++) m_anc[i] = NULLP;
            for (int i = 0; i < FRAMES; i++) begin
                m_pid[i] = 0; m_vpn[i] = 0; m_next[i] = NULLP;
            end
        end else begin
            if (m_phase == 2) begin
                m_phase = 0;
            end else if (m_phase == 1) begin
                m_left--;
                if (m_left == 0) begin
                    m_phase = 2;
                    m_fault = p_fault; m_vis = p_vis; m_paddr = p_paddr;
                end
            end else if (req_valid) begin
                ref_walk(int'(req_pid), int'(req_vpn), int'(req_off), p_fault, p_vis, p_paddr);
                m_left = 1 + p_vis;
                m_phase = 1;
            end
            if (anc_we) m_anc[anc_addr] = int'(anc_ptr);
            if (pte_we) begin
                m_pid[pte_addr] = int'(pte_pid);
                m_vpn[pte_addr] = int'(pte_vpn);
                m_next[pte_addr] = int'(pte_next);
            end
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every cycle away from the active edge (R11, R10 hold, plus scenario tag)
    always @(negedge clk) begin
        cmp("busy",   int'(busy),   (m_phase != 0) ? 1 : 0);
        cmp("done",   int'(done),   (m_phase == 2) ? 1 : 0);
        cmp("fault",  int'(fault),  m_fault);
        cmp("visits", int'(visits), m_vis);
        cmp("paddr",  int'(paddr),  m_paddr);
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic put_anchor(input int idx, input int ptr);
        @(negedge clk);
        anc_we = 1'b1; anc_addr = ANCHOR_W'(idx); anc_ptr = (FRAME_W+1)'(ptr);
        @(negedge clk);
        anc_we = 1'b0;
    endtask

    task automatic put_entry(input int idx, input int pid, input int vpn, input int nxt);
        @(negedge clk);
        pte_we = 1'b1; pte_addr = FRAME_W'(idx);
        pte_pid = PID_W'(pid); pte_vpn = VPN_W'(vpn); pte_next = (FRAME_W+1)'(nxt);
        @(negedge clk);
        pte_we = 1'b0;
    endtask

    task automatic lookup(input int pid, input int vpn, input int off);
        @(negedge clk);
        req_valid = 1'b1; req_pid = PID_W'(pid); req_vpn = VPN_W'(vpn); req_off = OFF_W'(off);
        @(negedge clk);
        req_valid = 1'b0;
        while (m_phase != 0) @(negedge clk);
    endtask

    // Holds req_valid high with other values throughout the walk (R9)
    task automatic lookup_noisy(input int pid, input int vpn, input int off);
        @(negedge clk);
        req_valid = 1'b1; req_pid = PID_W'(pid); req_vpn = VPN_W'(vpn); req_off = OFF_W'(off);
        @(negedge clk);
        req_pid = PID_W'(pid ^ 8'h3C); req_vpn = VPN_W'(vpn ^ 20'h0F0F0); req_off = '0;
        forever begin
            @(negedge clk);
            if (m_phase == 0) begin req_valid = 1'b0; break; end
        end
    endtask

    initial begin
        // R1: reset state and empty tables
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lookup(3, 20'h12345, 12'h001);

        // R4: single-slot hit
        tag = "R4";
        put_entry(7, 3, 20'h00100, NULLP);
        put_anchor(fold_key(3, 20'h00100), 7);
        lookup(3, 20'h00100, 12'hABC);

        // R2: a second key through its own folded bucket
        tag = "R2";
        put_entry(12, 8'hA5, 20'hABCDE, NULLP);
        put_anchor(fold_key(8'hA5, 20'hABCDE), 12);
        lookup(8'hA5, 20'hABCDE, 12'h5A5);

        // R5: three-slot chain, hit at the tail
        tag = "R5";
        put_entry(20, 1, 20'h00001, 21);
        put_entry(21, 1, 20'h00002, 22);
        put_entry(22, 9, 20'h00777, NULLP);
        put_anchor(fold_key(9, 20'h00777), 20);
        lookup(9, 20'h00777, 12'h321);

        // R6: colliding key absent from the chain (bits 0 and 6 fold together)
        tag = "R6";
        lookup(9, 20'h00777 ^ 20'h00041, 12'h111);

        // R7: same page, different owner, same bucket
        tag = "R7";
        lookup(9 ^ 8'h41, 20'h00777, 12'h222);

        // R9: requests held high during walk and result cycle are dropped
        tag = "R9";
        lookup_noisy(9, 20'h00777, 12'h0F0);
        lookup(8'hA5, 20'hABCDE, 12'h0AA);

        // R8: chain loops back on itself
        tag = "R8";
        put_entry(22, 9, 20'h00777, 20);
        lookup(9, 20'h00777 ^ 20'h00041, 12'h333);

        // R3: out-of-range anchor pointer and all-ones anchor
        tag = "R3";
        put_anchor(fold_key(4, 20'h00444), FRAMES);
        lookup(4, 20'h00444, 12'h444);
        put_anchor(fold_key(4, 20'h00444), NULLP);
        lookup(4, 20'h00444, 12'h445);

        // R10: rewritten slot governs the next walk
        tag = "R10";
        put_entry(7, 3, 20'h00200, NULLP);
        lookup(3, 20'h00100, 12'hABC);
        lookup(3, 20'h00200, 12'h00D);

        // R11: back-to-back lookups, pulse width and busy span
        tag = "R11";
        lookup(3, 20'h00200, 12'h00E);
        lookup(8'hA5, 20'hABCDE, 12'h00F);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule